// File: doc/BRIEF.md
# Reloadable UART Baud Rate Generator

This block times the bit rate for a UART. A 16-bit counter counts upward by one on each prescaled tick of a chosen source. When it passes its all-ones value it does not restart from zero. It is loaded from a programmable start value instead. Each such wrap produces a one-cycle pulse and flips a baud output. The baud output therefore runs at half the wrap rate. Both timing sources are clock-enable strobes inside the one clock domain: one stands for the system clock, the other for a second peripheral clock. The prescaler divides the chosen strobe by 1, 4, 12 or 48.

The start value is written a byte at a time. A write to the upper byte is only staged. A write to the lower byte commits both bytes together, so the counter never sees half of a new value. The counter takes a committed value at its next wrap. Enable, source and prescaler selection are level inputs.

A two-state controller runs the generator. ST_IDLE holds the outputs low and goes to ST_RUN when the enable input is high. That transition loads the counter and clears the prescaler. ST_RUN counts and goes back to ST_IDLE as soon as the enable input drops. Bit rates above one sixteenth of the system strobe rate are outside the supported range.

Top module: `baud_gen_top`

## Requirements
- R1: While reset is asserted, and afterwards until the generator is first enabled, `baud_out` and `ovf_pulse` are 0.
- R2: In ST_RUN the counter advances by one per prescaled tick. It wraps on the tick taken at 0xFFFF, reloading the committed start value. Wraps are therefore (65536 − start) prescaled ticks apart.
- R3: `cfg_presc` selects the prescale ratio: code 00 divides by 12, 01 by 4, 10 by 48 and 11 by 1.
- R4: `cfg_src` = 0 counts `sys_tick` strobes and `cfg_src` = 1 counts `per_tick` strobes. The strobe that is not selected has no effect on timing.
- R5: Each wrap raises `ovf_pulse` for exactly one cycle, in the cycle after the wrapping edge. `baud_out` inverts in that same cycle and changes at no other time while running.
- R6: With `cfg_en` low, the generator returns to ST_IDLE at the next edge. `baud_out` is then 0 and no `ovf_pulse` appears.
- R7: The edge that moves ST_IDLE to ST_RUN loads the counter with the start value, clears the prescaler and leaves `baud_out` at 0. With a divide-by-1 prescale and a strobe every cycle, the first pulse is visible 1 + (65536 − start) edges after `cfg_en` is raised.
- R8: `wr_hi` stages the upper byte only. `wr_lo` commits {staged upper byte, `wr_data`} as the start value. A value committed while running is used from the next wrap onward.
- R9: The full `baud_out` period is 2 × (65536 − start) × prescale ratio strobes of the selected source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all state |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en | input | 1 | Generator enable |
| cfg_src | input | 1 | Source select: 0 system strobe, 1 peripheral strobe |
| cfg_presc | input | 2 | Prescale code (00 ÷12, 01 ÷4, 10 ÷48, 11 ÷1) |
| sys_tick | input | 1 | System clock-enable strobe |
| per_tick | input | 1 | Peripheral clock-enable strobe |
| wr_hi | input | 1 | Stage `wr_data` as the upper start byte |
| wr_lo | input | 1 | Commit staged upper byte with `wr_data` as lower byte |
| wr_data | input | 8 | Byte written by `wr_hi` / `wr_lo` |
| ovf_pulse | output | 1 | One-cycle pulse per counter wrap |
| baud_out | output | 1 | Baud clock, inverts on every wrap |

## Verification
Some properties are checked locally on every cycle. The counter must step by exactly one between wraps and must take the start value on a wrap. The start register must stay stable unless the lower byte is written. The prescaler count must stay within range. Outputs must be quiet in ST_IDLE, and every running change of `baud_out` must coincide with a pulse.

Other behaviour needs the bench's scenarios. These cover the absolute wrap spacing under each prescale code and each source, the disregard of the unselected strobe, and the latency from enable to the first pulse. They also cover the fact that a staged upper byte alone changes nothing, while a committed value changes the spacing only from the next wrap. The behavioural reference model covers the remaining cycle-exact agreement.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;

    localparam int PRESC_W   = 6;
    localparam int PRESC_MAX = 48;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } bg_state_t;

    // Prescale ratio for each 2-bit code.
    function automatic logic [PRESC_W-1:0] presc_ratio(input logic [1:0] code);
        logic [PRESC_W-1:0] r;
        unique case (code)
            2'b00: r = PRESC_W'(12);
            2'b01: r = PRESC_W'(4);
            2'b10: r = PRESC_W'(48);
            2'b11: r = PRESC_W'(1);
            default: r = PRESC_W'(1);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/baud_presc.sv
module baud_presc
    import baud_gen_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               active,
    input  logic               src_tick,
    input  logic [PRESC_W-1:0] ratio,
    output logic               ptick
);

    logic [PRESC_W-1:0] pcnt;
    logic               at_end;

    // Comparison with >= tolerates a ratio lowered in mid-count.
    assign at_end = (pcnt >= (ratio - 1'b1));
    assign ptick  = active && src_tick && at_end;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt <= '0;
        end else if (clear) begin
            pcnt <= '0;
        end else if (active && src_tick) begin
            pcnt <= at_end ? '0 : pcnt + 1'b1;
        end
    end

    // R3: the division count never leaves the range of the largest ratio
    a_r3_pcnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        int'(pcnt) < PRESC_MAX);

    // R7: a clear leaves the prescaler at zero
    a_r7_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (pcnt == '0));

    // R4: without a source strobe the prescaler holds
    a_r4_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!src_tick && !clear) |=> $stable(pcnt));

endmodule

// File: rtl/baud_reload_regs.sv
module baud_reload_regs #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_hi,
    input  logic             wr_lo,
    input  logic [7:0]       wr_data,
    output logic [CNT_W-1:0] reload
);

    localparam int HI_W = CNT_W - 8;

    logic [HI_W-1:0] stage_hi;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_hi <= '0;
            reload   <= '0;
        end else begin
            if (wr_hi) begin
                stage_hi <= wr_data[HI_W-1:0];
            end
            if (wr_lo) begin
                reload <= {stage_hi, wr_data};
            end
        end
    end

    // R8: the committed value only moves on a lower-byte write
    a_r8_hold_without_lo: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_lo |=> $stable(reload));

    // R8: a lower-byte write lands in the low byte of the committed value
    a_r8_commit_low: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> (reload[7:0] == $past(wr_data)));

endmodule

// File: rtl/baud_timer.sv
module baud_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [CNT_W-1:0] reload,
    output logic             wrap
);

    logic [CNT_W-1:0] cnt;

    assign wrap = step && (&cnt);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= reload;
        end else if (step) begin
            cnt <= wrap ? reload : cnt + 1'b1;
        end
    end

    // R2: between wraps the counter moves up by exactly one per step
    a_r2_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && !(&cnt)) |=> (cnt == $past(cnt) + 1'b1));

    // R2: a wrap restarts from the committed start value
    a_r2_wrap_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !load) |=> (cnt == $past(reload)));

    // R7: a start loads the start value
    a_r7_load_value: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == $past(reload)));

endmodule

// File: rtl/baud_gen_top.sv
module baud_gen_top
    import baud_gen_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_en,
    input  logic       cfg_src,
    input  logic [1:0] cfg_presc,
    input  logic       sys_tick,
    input  logic       per_tick,
    input  logic       wr_hi,
    input  logic       wr_lo,
    input  logic [7:0] wr_data,
    output logic       ovf_pulse,
    output logic       baud_out
);

    bg_state_t          state, state_nxt;
    logic               start_load;
    logic               running;
    logic               src_tick;
    logic               ptick;
    logic               wrap;
    logic [CNT_W-1:0]   reload;
    logic [PRESC_W-1:0] ratio;

    assign start_load = (state == ST_IDLE) && cfg_en;
    assign running    = (state == ST_RUN) && cfg_en;
    assign src_tick   = cfg_src ? per_tick : sys_tick;
    assign ratio      = presc_ratio(cfg_presc);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // Transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (cfg_en)  state_nxt = ST_RUN;
            ST_RUN:  if (!cfg_en) state_nxt = ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            baud_out  <= 1'b0;
            ovf_pulse <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    baud_out  <= 1'b0;
                    ovf_pulse <= 1'b0;
                end
                ST_RUN: begin
                    if (!cfg_en) begin
                        baud_out  <= 1'b0;
                        ovf_pulse <= 1'b0;
                    end else begin
                        ovf_pulse <= wrap;
                        if (wrap) baud_out <= ~baud_out;
                    end
                end
                default: begin
                    baud_out  <= 1'b0;
                    ovf_pulse <= 1'b0;
                end
            endcase
        end
    end

    baud_reload_regs #(.CNT_W(CNT_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_hi   (wr_hi),
        .wr_lo   (wr_lo),
        .wr_data (wr_data),
        .reload  (reload)
    );

    baud_presc u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (start_load),
        .active   (running),
        .src_tick (src_tick),
        .ratio    (ratio),
        .ptick    (ptick)
    );

    baud_timer #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (start_load),
        .step   (ptick),
        .reload (reload),
        .wrap   (wrap)
    );

    // R6: idle keeps both outputs low
    a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (!ovf_pulse && !baud_out));

    // R5: a wrap while enabled is marked by a pulse in the next cycle
    a_r5_wrap_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (running && wrap) |=> ovf_pulse);

    // R5: while running, the baud output changes only together with a pulse
    a_r5_toggle_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_RUN) && ($past(state) == ST_RUN) && (baud_out != $past(baud_out)))
            |-> ovf_pulse);

    // R7: the start edge leaves the baud output low
    a_r7_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        start_load |=> !baud_out);

endmodule

// File: tb/baud_gen_top_bench.sv
module baud_gen_top_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_en = 1'b0;
    logic       cfg_src = 1'b0;
    logic [1:0] cfg_presc = 2'b11;
    logic       sys_tick = 1'b0;
    logic       per_tick = 1'b0;
    logic       wr_hi = 1'b0;
    logic       wr_lo = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       ovf_pulse;
    logic       baud_out;

    int    errors = 0;
    int    checks = 0;
    int    cyc = 0;
    string cur_req = "R1";
    bit    sys_every = 1'b1;
    int    phase = 0;
    bit    done = 1'b0;

    always #4 clk = ~clk;

    baud_gen_top u_baud_gen_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_en    (cfg_en),
        .cfg_src   (cfg_src),
        .cfg_presc (cfg_presc),
        .sys_tick  (sys_tick),
        .per_tick  (per_tick),
        .wr_hi     (wr_hi),
        .wr_lo     (wr_lo),
        .wr_data   (wr_data),
        .ovf_pulse (ovf_pulse),
        .baud_out  (baud_out)
    );

    function automatic int ratio_of(input logic [1:0] code);
        case (code)
            2'b00:   return 12;
            2'b01:   return 4;
            2'b10:   return 48;
            default: return 1;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Strobe sources, driven away from the active edge
    always @(negedge clk) begin
        phase <= phase + 1;
        sys_tick <= sys_every ? 1'b1 : phase[0];
        per_tick <= ((phase % 3) == 0);
    end

    // Behavioural reference model
    bit m_run = 0, m_baud = 0, m_ovf = 0;
    int m_cnt = 0, m_pc = 0, m_reload = 0, m_stage = 0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            m_run = 0; m_baud = 0; m_ovf = 0;
            m_cnt = 0; m_pc = 0; m_reload = 0; m_stage = 0;
        end else begin
            m_ovf = 0;
            if (!m_run) begin
                if (cfg_en) begin
                    m_run = 1; m_cnt = m_reload; m_pc = 0; m_baud = 0;
                end
            end else if (!cfg_en) begin
                m_run = 0; m_baud = 0;
            end else if (cfg_src ? per_tick : sys_tick) begin
                if (m_pc >= ratio_of(cfg_presc) - 1) begin
                    m_pc = 0;
                    if (m_cnt == 65535) begin
                        m_cnt = m_reload; m_baud = !m_baud; m_ovf = 1;
                    end else begin
                        m_cnt = m_cnt + 1;
                    end
                end else begin
                    m_pc = m_pc + 1;
                end
            end
            if (wr_hi) m_stage = int'(wr_data);
            if (wr_lo) m_reload = m_stage * 256 + int'(wr_data);
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(baud_out == m_baud, {cur_req, " baud_out vs model"}, baud_out, m_baud);
            check(ovf_pulse == m_ovf, {cur_req, " ovf_pulse vs model"}, ovf_pulse, m_ovf);
        end
    end

    // Watchdog
    always @(posedge clk) begin
        if (cyc > 150000 && !done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic write_start(input logic [15:0] v);
        @(negedge clk); wr_hi = 1'b1; wr_data = v[15:8];
        @(negedge clk); wr_hi = 1'b0; wr_lo = 1'b1; wr_data = v[7:0];
        @(negedge clk); wr_lo = 1'b0;
    endtask

    task automatic gap(output int g);
        int t0;
        do @(negedge clk); while (!ovf_pulse);
        t0 = cyc;
        do @(negedge clk); while (!ovf_pulse);
        g = cyc - t0;
    endtask

    task automatic stop_gen();
        @(negedge clk); cfg_en = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        int g;
        int n;
        int seen;
        // R1: reset state
        repeat (3) @(negedge clk);
        check(baud_out == 1'b0, "R1 baud in reset", baud_out, 0);
        check(ovf_pulse == 1'b0, "R1 pulse in reset", ovf_pulse, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(baud_out == 1'b0 && ovf_pulse == 1'b0, "R1 outputs before enable",
              {baud_out, ovf_pulse}, 0);

        // R2 / R3: spacing for each prescale code at start 0xFFF8
        cur_req = "R3";
        write_start(16'hFFF8);
        for (int c = 0; c < 4; c++) begin
            cfg_presc = 2'(c);
            @(negedge clk); cfg_en = 1'b1;
            gap(g);
            check(g == 8 * ratio_of(2'(c)), "R3 wrap spacing per code", g, 8 * ratio_of(2'(c)));
            stop_gen();
        end

        // R2: divide-by-1, start 0xFFF0
        cur_req = "R2";
        cfg_presc = 2'b11;
        write_start(16'hFFF0);
        @(negedge clk); cfg_en = 1'b1;
        gap(g);
        check(g == 16, "R2 wrap spacing", g, 16);
        stop_gen();

        // R4: source selection with distinct strobe rates
        cur_req = "R4";
        sys_every = 1'b0;
        write_start(16'hFFFC);
        cfg_presc = 2'b01;
        cfg_src = 1'b1;
        @(negedge clk); cfg_en = 1'b1;
        gap(g);
        check(g == 48, "R4 peripheral source spacing", g, 48);
        stop_gen();
        cfg_src = 1'b0;
        @(negedge clk); cfg_en = 1'b1;
        gap(g);
        check(g == 32, "R4 system source spacing", g, 32);
        stop_gen();
        sys_every = 1'b1;

        // R9: baud period, code 00 and start 0xFFFD
        cur_req = "R9";
        cfg_presc = 2'b00;
        write_start(16'hFFFD);
        @(negedge clk); cfg_en = 1'b1;
        do @(negedge clk); while (!baud_out);
        n = cyc;
        do @(negedge clk); while (baud_out);
        do @(negedge clk); while (!baud_out);
        check(cyc - n == 72, "R9 baud period", cyc - n, 72);

        // R6: disable while running
        cur_req = "R6";
        @(negedge clk); cfg_en = 1'b0;
        @(negedge clk);
        check(baud_out == 1'b0, "R6 baud low after disable", baud_out, 0);
        seen = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (ovf_pulse || baud_out) seen++;
        end
        check(seen == 0, "R6 quiet while disabled", seen, 0);

        // R7: enable-to-first-pulse latency, start 0xFFF8, divide by 1
        cur_req = "R7";
        cfg_presc = 2'b11;
        write_start(16'hFFF8);
        @(negedge clk); cfg_en = 1'b1;
        n = 0;
        do begin
            @(negedge clk); n++;
            if (n == 1) check(baud_out == 1'b0, "R7 baud low after start", baud_out, 0);
        end while (!ovf_pulse && n < 100);
        check(n == 9, "R7 first pulse latency", n, 9);

        // R5: pulse lasts one cycle and baud toggled with it
        cur_req = "R5";
        @(negedge clk);
        check(ovf_pulse == 1'b0, "R5 pulse width one cycle", ovf_pulse, 0);
        check(baud_out == 1'b1, "R5 baud toggled on wrap", baud_out, 1);

        // R8: staged upper byte alone changes nothing
        cur_req = "R8";
        @(negedge clk); wr_hi = 1'b1; wr_data = 8'h12;
        @(negedge clk); wr_hi = 1'b0;
        gap(g);
        check(g == 8, "R8 staged byte ignored", g, 8);
        gap(g);
        check(g == 8, "R8 staged byte ignored again", g, 8);
        // commit 0xFFF0 while running: new spacing from next wrap
        write_start(16'hFFF0);
        gap(g);
        gap(g);
        check(g == 16, "R8 committed value in use", g, 16);
        stop_gen();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule